// File: doc/BRIEF.md
# Split-Access 64-bit CSR Bridge

This block connects a 32-bit register bus to a bank of 64-bit control and status registers. The registers sit one per 64-byte slot. Each 64-bit register is seen upstream as two 32-bit words. The word at offset 0 is the low half and the word at offset 4 is the high half, which is little-endian order.

One holding latch is shared by reads and writes. It turns each pair of 32-bit accesses into a single 64-bit access downstream:
- **Writes.** Writing the low word only places the data in the latch. Writing the high word commits `{high word, latch}` to the register in one step.
- **Reads.** Reading the low word returns the low half and copies the high half into the latch. Reading the high word returns the latch and makes no downstream access.

The bridge also decides whether an address is decoded:
- The register bank claims a slot through `dn_hit`.
- A parameter mask marks reserved slots. Reserved slots are decoded but have no storage behind them.
- Anything else is undecoded. An undecoded read returns all-ones, and an undecoded commit is dropped. Both raise a one-cycle error flag.

There is no back-pressure on either side. One access is accepted every cycle, and read data and the error flag appear registered in the cycle that follows.

Top module: `csr_split_bridge`

## Requirements
- R1: A write with `up_addr[2]`=0 loads `up_wdata` into the holding latch. It never raises `dn_we` and never raises `up_err`, whatever the other address bits are.
- R2: A write with `up_addr[5:0]`=6'h04 to a slot claimed by `dn_hit` that is not reserved raises `dn_we` in that same cycle. It drives `dn_addr`=`up_addr[AW-1:6]` and `dn_wdata`={`up_wdata`, latch}. Bits 63:32 come from the bus word and bits 31:0 from the latch.
- R3: A read with `up_addr[5:0]`=0 to a claimed, non-reserved slot returns `dn_rdata[31:0]` on `up_rdata` one cycle later. It also loads `dn_rdata[63:32]` into the latch.
- R4: Any read with `up_addr[2]`=1 returns the latch contents one cycle later. This holds whether the address is decoded or not. It leaves the latch unchanged, raises no error and makes no downstream write.
- R5: A read with `up_addr[2]`=0 is undecoded if offset bits [5:3] or [1:0] are nonzero, or if the slot is neither reserved nor claimed. Such a read returns 32'hFFFF_FFFF with `up_err`=1 one cycle later and leaves the latch unchanged.
- R6: A write with `up_addr[2]`=1 to an undecoded address (same rule as R5) is dropped with no `dn_we`. It raises `up_err` for one cycle afterwards.
- R7: A slot whose bit is set in `RSVD_MASK` reads as zero on the low word, and that read loads zero into the latch. A high-word write to it is ignored. Neither case raises an error.
- R8: After reset, `up_rdata`=0, `up_err`=0 and the latch holds zero.
- R9: When `up_wr` and `up_rd` are both high, only the write takes effect and `up_rdata` keeps its previous value.
- R10: `up_err` is high only in the cycle after an access that R5 or R6 marks as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_addr | input | AW | Upstream byte address |
| up_wdata | input | 32 | Upstream write word |
| up_wr | input | 1 | Upstream write strobe |
| up_rd | input | 1 | Upstream read strobe |
| up_rdata | output | 32 | Registered read word |
| up_err | output | 1 | Registered access-error pulse |
| dn_addr | output | AW-6 | Register slot index |
| dn_wdata | output | 64 | 64-bit commit data |
| dn_we | output | 1 | 64-bit commit strobe |
| dn_rdata | input | 64 | Register contents for `dn_addr` |
| dn_hit | input | 1 | Register bank claims `dn_addr` |

## Verification
The bench tries paired low/high writes followed by low/high reads on two different slots. This shows that the halves land in the right places and that the latch carries the upper word from one access to the next.

Several access patterns are placed between a low read and the following high read: reads with stray offset bits, reads of unclaimed slots, and reads of reserved slots. The bench then checks the high read, which tells a latch that is correctly left alone apart from one that is wrongly loaded.

Writes to reserved and unclaimed slots are followed by a read-back of a neighbouring slot. This separates an ignored write from a misdirected one. A simultaneous read and write checks that the write takes precedence.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
  typedef enum logic [3:0] {
    K_IDLE,     // no access
    K_STAGE,    // low write: load latch
    K_COMMIT,   // high write to a live register
    K_WIGNORE,  // high write to a reserved slot
    K_WBAD,     // high write to undecoded address
    K_RLOW,     // low read of a live register
    K_RZERO,    // low read of a reserved slot
    K_RHIGH,    // high read: latch
    K_RBAD      // low read of undecoded address
  } acc_kind_e;
endpackage

// File: rtl/csrb_decode.sv
module csrb_decode
  import csrb_pkg::*;
#(
  parameter int AW = 12,
  localparam int SW = AW - 6,
  localparam int SLOTS = 1 << SW,
  parameter logic [SLOTS-1:0] RSVD_MASK = '0
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic          hit,
  output acc_kind_e     kind
);
  logic [SW-1:0] slot;
  logic          clean;
  logic          rsvd;

  assign slot  = addr[AW-1:6];
  assign clean = (addr[5:3] == 3'd0) && (addr[1:0] == 2'd0);
  assign rsvd  = RSVD_MASK[slot];

  always_comb begin
    kind = K_IDLE;
    if (wr) begin
      if (!addr[2])      kind = K_STAGE;
      else if (!clean)   kind = K_WBAD;
      else if (rsvd)     kind = K_WIGNORE;
      else if (hit)      kind = K_COMMIT;
      else               kind = K_WBAD;
    end else if (rd) begin
      if (addr[2])       kind = K_RHIGH;
      else if (!clean)   kind = K_RBAD;
      else if (rsvd)     kind = K_RZERO;
      else if (hit)      kind = K_RLOW;
      else               kind = K_RBAD;
    end
  end
endmodule

// File: rtl/csrb_hold.sv
module csrb_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/csrb_resp.sv
module csrb_resp
  import csrb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_kind_e     kind,
  input  logic [DW-1:0] reg_lo,
  input  logic [DW-1:0] hold_q,
  output logic [DW-1:0] rdata_q,
  output logic          err_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (kind == K_RBAD) || (kind == K_WBAD);
      case (kind)
        K_RLOW:  rdata_q <= reg_lo;
        K_RZERO: rdata_q <= '0;
        K_RHIGH: rdata_q <= hold_q;
        K_RBAD:  rdata_q <= '1;
        default: rdata_q <= rdata_q;
      endcase
    end
  end
endmodule

// File: rtl/csr_split_bridge.sv
module csr_split_bridge
  import csrb_pkg::*;
#(
  parameter int AW = 12,
  localparam int SW = AW - 6,
  localparam int SLOTS = 1 << SW,
  localparam int HW = 32,
  localparam int RW = 2 * HW,
  parameter logic [SLOTS-1:0] RSVD_MASK = 64'h0000_0000_0003_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] up_addr,
  input  logic [HW-1:0] up_wdata,
  input  logic          up_wr,
  input  logic          up_rd,
  output logic [HW-1:0] up_rdata,
  output logic          up_err,
  output logic [SW-1:0] dn_addr,
  output logic [RW-1:0] dn_wdata,
  output logic          dn_we,
  input  logic [RW-1:0] dn_rdata,
  input  logic          dn_hit
);
  acc_kind_e     kind;
  logic [HW-1:0] hold_q;
  logic          hold_ld;
  logic [HW-1:0] hold_d;

  csrb_decode #(.AW(AW), .RSVD_MASK(RSVD_MASK)) u_dec (
    .addr (up_addr),
    .wr   (up_wr),
    .rd   (up_rd),
    .hit  (dn_hit),
    .kind (kind)
  );

  always_comb begin
    hold_ld = 1'b0;
    hold_d  = '0;
    case (kind)
      K_STAGE: begin hold_ld = 1'b1; hold_d = up_wdata;         end
      K_RLOW:  begin hold_ld = 1'b1; hold_d = dn_rdata[RW-1:HW]; end
      K_RZERO: begin hold_ld = 1'b1; hold_d = '0;               end
      default: ;
    endcase
  end

  csrb_hold #(.DW(HW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (hold_ld),
    .d     (hold_d),
    .q     (hold_q)
  );

  csrb_resp #(.DW(HW)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .reg_lo  (dn_rdata[HW-1:0]),
    .hold_q  (hold_q),
    .rdata_q (up_rdata),
    .err_q   (up_err)
  );

  assign dn_addr  = up_addr[AW-1:6];
  assign dn_wdata = {up_wdata, hold_q};
  assign dn_we    = (kind == K_COMMIT);
endmodule

// File: rtl/csr_split_bridge_chk.sv
module csr_split_bridge_chk #(
  parameter int AW = 12,
  localparam int SW = AW - 6,
  localparam int SLOTS = 1 << SW,
  parameter logic [SLOTS-1:0] RSVD_MASK = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] up_addr,
  input logic [31:0]   up_wdata,
  input logic          up_wr,
  input logic          up_rd,
  input logic [31:0]   up_rdata,
  input logic          up_err,
  input logic          dn_we,
  input logic [63:0]   dn_wdata,
  input logic [63:0]   dn_rdata,
  input logic          dn_hit,
  input logic [31:0]   hold_q
);
  logic rsvd, clean, rd_only, bad;
  assign rsvd    = RSVD_MASK[up_addr[AW-1:6]];
  assign clean   = (up_addr[5:3] == 3'd0) && (up_addr[1:0] == 2'd0);
  assign rd_only = up_rd && !up_wr;
  assign bad     = !clean || (!rsvd && !dn_hit);

  a_r1_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    (up_wr && !up_addr[2]) |-> !dn_we);
  a_r1_stage_load: assert property (@(posedge clk) disable iff (!rst_n)
    (up_wr && !up_addr[2]) |=> (hold_q == $past(up_wdata) && !up_err));
  a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
    dn_we |-> (up_wr && up_addr[5:0] == 6'h04 && !rsvd && dn_hit && dn_wdata == {up_wdata, hold_q}));
  a_r3_low_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && !up_addr[2] && clean && !rsvd && dn_hit) |=>
      (up_rdata == $past(dn_rdata[31:0]) && hold_q == $past(dn_rdata[63:32]) && !up_err));
  a_r4_high_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && up_addr[2]) |=> (up_rdata == $past(hold_q) && $stable(hold_q) && !up_err));
  a_r5_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && !up_addr[2] && bad) |=> (up_err && up_rdata == 32'hFFFF_FFFF && $stable(hold_q)));
  a_r6_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    (up_wr && up_addr[2] && bad) |=> up_err);
  a_r7_rsvd_write: assert property (@(posedge clk) disable iff (!rst_n)
    (up_wr && rsvd) |-> !dn_we);
  a_r9_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (up_wr && up_rd) |=> $stable(up_rdata));
  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    up_err |-> $past(up_wr || up_rd));
endmodule

bind csr_split_bridge csr_split_bridge_chk #(.AW(AW), .RSVD_MASK(RSVD_MASK)) u_chk (.*);

// File: tb/csr_split_bridge_test.sv
module csr_split_bridge_test;
  localparam int CLK_P = 10;
  localparam int NV = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic        up_wr = 1'b0;
  logic        up_rd = 1'b0;
  logic [31:0] up_rdata;
  logic        up_err;
  logic [5:0]  dn_addr;
  logic [63:0] dn_wdata;
  logic        dn_we;
  logic [63:0] dn_rdata;
  logic        dn_hit;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0] bank [0:15];
  logic        we_seen;
  logic [63:0] wd_seen;
  logic [5:0]  ad_seen;

  always #(CLK_P/2) clk = ~clk;

  csr_split_bridge uut (
    .clk(clk), .rst_n(rst_n), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_wr(up_wr), .up_rd(up_rd), .up_rdata(up_rdata), .up_err(up_err),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_we(dn_we),
    .dn_rdata(dn_rdata), .dn_hit(dn_hit)
  );

  // register bank model: slots 0..15 are claimed
  assign dn_hit   = (dn_addr < 6'd16);
  assign dn_rdata = dn_hit ? bank[dn_addr[3:0]] : 64'h0;
  always @(posedge clk) if (dn_we && dn_hit) bank[dn_addr[3:0]] <= dn_wdata;

  // {check_rdata, is_write, addr, wdata, exp_rdata, exp_err}
  localparam logic [78:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 12'h040, 32'h1111_2222, 32'h0, 1'b0},          // R1 stage slot1
    {1'b0, 1'b1, 12'h044, 32'hAAAA_BBBB, 32'h0, 1'b0},          // R2 commit slot1
    {1'b1, 1'b0, 12'h040, 32'h0, 32'h1111_2222, 1'b0},          // R3 R10 low read
    {1'b1, 1'b0, 12'h044, 32'h0, 32'hAAAA_BBBB, 1'b0},          // R4 high from latch
    {1'b0, 1'b1, 12'h0C0, 32'hDEAD_BEEF, 32'h0, 1'b0},          // R1 stage slot3
    {1'b0, 1'b1, 12'h0C4, 32'h0123_4567, 32'h0, 1'b0},          // R2 commit slot3
    {1'b1, 1'b0, 12'h0C0, 32'h0, 32'hDEAD_BEEF, 1'b0},          // R3
    {1'b1, 1'b0, 12'h048, 32'h0, 32'hFFFF_FFFF, 1'b1},          // R5 offset bit 3
    {1'b1, 1'b0, 12'h500, 32'h0, 32'hFFFF_FFFF, 1'b1},          // R5 unclaimed slot
    {1'b1, 1'b0, 12'h0C4, 32'h0, 32'h0123_4567, 1'b0},          // R5 latch kept, R4
    {1'b1, 1'b0, 12'h400, 32'h0, 32'h0, 1'b0},                  // R7 reserved reads 0
    {1'b1, 1'b0, 12'h404, 32'h0, 32'h0, 1'b0},                  // R7 latch zeroed
    {1'b0, 1'b1, 12'h400, 32'h5, 32'h0, 1'b0},                  // R1
    {1'b0, 1'b1, 12'h404, 32'h6, 32'h0, 1'b0},                  // R7 ignored, no err
    {1'b1, 1'b0, 12'h400, 32'h0, 32'h0, 1'b0},                  // R7 still zero
    {1'b0, 1'b1, 12'h502, 32'h9, 32'h0, 1'b0},                  // R1 odd offset stages
    {1'b0, 1'b1, 12'h504, 32'hA, 32'h0, 1'b1},                  // R6 unclaimed commit
    {1'b1, 1'b0, 12'h040, 32'h0, 32'h1111_2222, 1'b0},          // R6 slot1 untouched
    {1'b1, 1'b0, 12'h504, 32'h0, 32'hAAAA_BBBB, 1'b0}           // R4 undecoded high read
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access: drive at negedge, capture downstream strobe, release at next negedge
  task automatic access(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] d);
    up_wr = wr; up_rd = rd; up_addr = a; up_wdata = d;
    #1;
    we_seen = dn_we; wd_seen = dn_wdata; ad_seen = dn_addr;
    @(negedge clk);
    up_wr = 1'b0; up_rd = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) bank[i] = 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    check(up_rdata == 32'h0, "R8 rdata", {32'h0, up_rdata}, 64'h0);
    check(up_err == 1'b0, "R8 err", {63'h0, up_err}, 64'h0);
    access(1'b0, 1'b1, 12'h004, 32'h0);
    check(up_rdata == 32'h0 && !up_err, "R8 latch zero", {32'h0, up_rdata}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [78:0] v;
      v = VEC[i];
      access(v[77], !v[77], v[76:65], v[64:33]);
      check(up_err == v[0], $sformatf("R10 table[%0d] err", i), {63'h0, up_err}, {63'h0, v[0]});
      if (v[78])
        check(up_rdata == v[32:1], $sformatf("table[%0d] rdata", i), {32'h0, up_rdata}, {32'h0, v[32:1]});
    end

    // R1: low write never commits
    access(1'b1, 1'b0, 12'h080, 32'h3333_4444);
    check(!we_seen, "R1 no dn_we", {63'h0, we_seen}, 64'h0);
    check(bank[2] == 64'h0, "R1 bank untouched", bank[2], 64'h0);
    // R2: high write commits in the same cycle with the latch as low half
    access(1'b1, 1'b0, 12'h084, 32'h5555_6666);
    check(we_seen && ad_seen == 6'd2, "R2 strobe/addr", {57'h0, we_seen, ad_seen}, {57'h0, 1'b1, 6'd2});
    check(wd_seen == 64'h5555_6666_3333_4444, "R2 wdata", wd_seen, 64'h5555_6666_3333_4444);
    check(bank[2] == 64'h5555_6666_3333_4444, "R2 bank", bank[2], 64'h5555_6666_3333_4444);
    // R7: reserved commit gives no strobe
    access(1'b1, 1'b0, 12'h444, 32'h7);
    check(!we_seen && !up_err, "R7 reserved commit", {63'h0, we_seen}, 64'h0);
    // R6: misaligned commit dropped
    access(1'b1, 1'b0, 12'h08C, 32'h8);
    check(!we_seen && up_err, "R6 misaligned commit", {62'h0, we_seen, up_err}, 64'h1);
    // R10: error is a single-cycle pulse
    @(negedge clk);
    check(!up_err, "R10 err pulse", {63'h0, up_err}, 64'h0);
    // R9: simultaneous read and write
    access(1'b0, 1'b1, 12'h080, 32'h0);
    check(up_rdata == 32'h3333_4444, "R9 setup", {32'h0, up_rdata}, 64'h3333_4444);
    access(1'b1, 1'b1, 12'h0C0, 32'h0000_0077);
    check(up_rdata == 32'h3333_4444, "R9 rdata held", {32'h0, up_rdata}, 64'h3333_4444);
    access(1'b1, 1'b0, 12'h0C4, 32'h0000_0088);
    check(bank[3] == 64'h0000_0088_0000_0077, "R9 write took effect", bank[3], 64'h0000_0088_0000_0077);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule